// File: doc/BRIEF.md
# Counted Loop Datapath with Per-Block Execution Bits

This block is the hardware form of a small counted loop: a counter starts at zero, gains one on every pass, and the loop repeats while the incremented value stays below a bound. When the loop ends, a post-loop result is formed by adding an operand to the final counter value. The loop has no encoded state machine. Each basic block owns a one-bit execution signal that is high in the cycle control is in that block. The pre-loop entry bit, the registered back-edge bit and the exit bit together form the loop's one-hot state.

The loop-header bit is the OR of an accepted entry pulse and the registered back-edge bit. The counter's merge point is a multiplexer steered by the entry bit. The back edge holds a register for the counter and a register for its execution bit. The first pass is computed in the cycle of the entry pulse. The post-loop addition is computed in the cycle of the last pass. A one-cycle entry pulse therefore produces a one-cycle exit pulse after the minimum number of cycles. The user pulses `entry_i` for one cycle, holds the operand on `b_i`, and captures `result_o` in the cycle `exit_o` is high.

Top module: `loop_exec`

## Requirements
- R1: After the asynchronous active-low reset `rst_ni` is released, `exit_o` stays low until an entry pulse is accepted.
- R2: An entry pulse accepted in cycle 0 produces `exit_o` high in cycle BOUND-1. That is cycle 7 with the defaults BOUND=8, WIDTH=8.
- R3: `exit_o` is high for exactly one cycle for each accepted entry pulse.
- R4: In the exit cycle, `result_o` equals (final counter + `b_i`) mod 2^WIDTH, where the final counter equals BOUND. With the defaults this is (b+8) mod 256. `b_i` is taken combinationally in the exit cycle, so earlier values of `b_i` have no effect.
- R5: An entry pulse is ignored while the back-edge bit is set. That covers every cycle after the accepted entry, up to and including the exit cycle. Such a pulse neither moves nor adds an exit pulse.
- R6: An entry pulse in the cycle right after an exit cycle is accepted, and it produces its own exit pulse BOUND-1 cycles later.
- R7: The phi multiplexer selects 0 when an entry is accepted and the registered back-edge counter otherwise. Each back-edge pass therefore advances the counter by exactly 1.
- R8: When the loop exits, the back-edge bit is clear in the next cycle, so the one-hot loop state returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| entry_i | input | 1 | One-cycle pre-loop execution bit |
| b_i | input | WIDTH | Operand added by the post-loop code |
| exit_o | output | 1 | Post-loop execution bit, a one-cycle pulse |
| result_o | output | WIDTH | Final counter plus `b_i`, valid while `exit_o` is high |

## Verification
The embedded assertions check four properties on every cycle:
- the counter advances by one across each registered back edge;
- an accepted entry is followed by the counter value 1 and a set back-edge bit;
- the exit bit never holds for two cycles;
- the back-edge bit is clear after an exit.

Only the bench scenarios can show the end-to-end timing from entry to exit and the arithmetic of the result for every operand value. The same holds for the rejection of mid-loop entry pulses, the acceptance of an entry right after an exit, and the insensitivity to `b_i` before the exit cycle.

// File: rtl/loop_pkg.sv
package loop_pkg;
  localparam int unsigned DEF_WIDTH = 8;
  localparam int unsigned DEF_BOUND = 8;

  // one-hot loop state seen from outside the header
  typedef struct packed {
    logic entry_acc;
    logic back;
    logic leave;
  } exec_bits_t;
endpackage

// File: rtl/exec_bit_ctrl.sv
module exec_bit_ctrl (
  input  logic entry_i,
  input  logic be_q_i,
  input  logic cond_i,
  output logic entry_acc_o,
  output logic hdr_o,
  output logic be_d_o,
  output logic exit_o
);
  // entries are dropped while a pass is in flight
  assign entry_acc_o = entry_i & ~be_q_i;
  assign hdr_o       = entry_acc_o | be_q_i;
  // branch steers the header bit to back edge or exit
  assign be_d_o      = hdr_o & cond_i;
  assign exit_o      = hdr_o & ~cond_i;
endmodule

// File: rtl/phi_mux.sv
module phi_mux #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             sel_init_i,
  input  logic [WIDTH-1:0] init_i,
  input  logic [WIDTH-1:0] back_i,
  output logic [WIDTH-1:0] val_o
);
  assign val_o = sel_init_i ? init_i : back_i;
endmodule

// File: rtl/backedge_reg.sv
module backedge_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             be_d_i,
  input  logic [WIDTH-1:0] cnt_d_i,
  output logic             be_q_o,
  output logic [WIDTH-1:0] cnt_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      be_q_o  <= 1'b0;
      cnt_q_o <= '0;
    end else begin
      be_q_o <= be_d_i;
      if (be_d_i) cnt_q_o <= cnt_d_i;
    end
  end
endmodule

// File: rtl/loop_exec.sv
module loop_exec
  import loop_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH,
  parameter int unsigned BOUND = DEF_BOUND
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             entry_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             exit_o,
  output logic [WIDTH-1:0] result_o
);
  localparam logic [WIDTH-1:0] BOUND_W = WIDTH'(BOUND);
  localparam logic [WIDTH-1:0] STEP_W  = WIDTH'(1);
  localparam logic [WIDTH-1:0] INIT_W  = '0;

  exec_bits_t       xb;
  logic             hdr, be_d, be_q, cond;
  logic [WIDTH-1:0] i_phi, i_next, cnt_q;

  exec_bit_ctrl u_ctrl (
    .entry_i     (entry_i),
    .be_q_i      (be_q),
    .cond_i      (cond),
    .entry_acc_o (xb.entry_acc),
    .hdr_o       (hdr),
    .be_d_o      (be_d),
    .exit_o      (xb.leave)
  );

  phi_mux #(.WIDTH(WIDTH)) u_phi (
    .sel_init_i (xb.entry_acc),
    .init_i     (INIT_W),
    .back_i     (cnt_q),
    .val_o      (i_phi)
  );

  assign i_next = i_phi + STEP_W;
  assign cond   = i_next < BOUND_W;

  backedge_reg #(.WIDTH(WIDTH)) u_be (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .be_d_i  (be_d),
    .cnt_d_i (i_next),
    .be_q_o  (be_q),
    .cnt_q_o (cnt_q)
  );

  assign xb.back  = be_q;
  assign exit_o   = xb.leave;
  assign result_o = i_next + b_i;

  // R7: counter advances by one across each back edge
  assert_backedge_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (be_q && hdr && cond) |=> (cnt_q == $past(cnt_q) + STEP_W));

  // R2: accepted entry lands in the first back-edge pass
  generate
    if (BOUND > 1) begin : g_entry_chk
      assert_entry_first_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        xb.entry_acc |=> (be_q && cnt_q == STEP_W));
    end
  endgenerate

  // R3: exit bit is a single-cycle pulse
  assert_exit_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_o |=> !exit_o);

  // R8: loop state returns to idle after exit
  assert_idle_after_exit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_o |=> !be_q);
endmodule

// File: tb/loop_exec_bench.sv
`timescale 1ns/1ps
module loop_exec_bench;
  localparam int W = 8;
  localparam int BOUND = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         entry = 1'b0;
  logic [W-1:0] b = '0;
  logic         exit_w;
  logic [W-1:0] result_w;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  loop_exec #(.WIDTH(W), .BOUND(BOUND)) u_loop_exec (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .entry_i  (entry),
    .b_i      (b),
    .exit_o   (exit_w),
    .result_o (result_w)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // inputs change at negedge, outputs sampled 1 ns later
  task automatic step(input logic e, input logic [W-1:0] bv);
    @(negedge clk);
    entry = e;
    b = bv;
    #1;
  endtask

  // one full run; cycle 0 carries the entry pulse
  task automatic run_one(input int tgt);
    for (int k = 0; k < BOUND + 2; k++) begin
      logic [W-1:0] bv;
      bv = (k == BOUND - 1) ? W'(tgt) : W'(tgt + 37 * k + 5);
      step(k == 0, bv);
      chk("R2/R3 exit timing", int'(exit_w), int'(k == BOUND - 1));
      if (k == BOUND - 1)
        chk("R4 result", int'(result_w), (tgt + BOUND) % (1 << W));
    end
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state and idle quiet
    repeat (3) step(1'b0, '0);
    chk("R1 exit in reset", int'(exit_w), 0);
    rst_n = 1'b1;
    for (int k = 0; k < 12; k++) begin
      step(1'b0, W'(k * 19));
      chk("R1 idle no exit", int'(exit_w), 0);
    end

    // R2 R3 R4 R7: sweep every operand value
    for (int t = 0; t < (1 << W); t++) run_one(t);

    // R5: entries mid-loop and in the exit cycle are ignored
    for (int k = 0; k < 2 * BOUND + 2; k++) begin
      step(k == 0 || k == 3 || k == BOUND - 1, 8'd100);
      chk("R5 ignored entry", int'(exit_w), int'(k == BOUND - 1));
    end

    // R6 R8: entry right after an exit starts a fresh loop
    for (int k = 0; k < 2 * BOUND + 2; k++) begin
      step(k == 0 || k == BOUND, 8'd250);
      chk("R6 back-to-back exit", int'(exit_w),
          int'(k == BOUND - 1 || k == 2 * BOUND - 1));
      if (k == 2 * BOUND - 1)
        chk("R6 back-to-back result", int'(result_w), (250 + BOUND) % (1 << W));
    end

    // R1: reset mid-loop cancels the pending exit
    step(1'b1, '0);
    step(1'b0, '0);
    rst_n = 1'b0;
    step(1'b0, '0);
    rst_n = 1'b1;
    for (int k = 0; k < BOUND + 2; k++) begin
      step(1'b0, '0);
      chk("R1 reset cancels loop", int'(exit_w), 0);
    end
    run_one(3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule